// File: doc/BRIEF.md
# FIFO DMA Ready Signal Generator

This block drives the two active-low handshake lines a DMA controller watches to learn when a serial port wants service: a receive-ready line and a transmit-ready line. It sees only the fill levels of the receive and transmit FIFOs (each `DEPTH` entries, 32 by default), a level flag saying the receive trigger level has been reached, and a pulse marking a receive timeout. The FIFOs, the trigger programming and the timeout timer live elsewhere.

Two modes exist. Single-transfer mode (mode 0) asks for service one character at a time. It also covers operation with the FIFOs switched off, where a count of 0 or 1 stands for an empty or full holding register. Block mode (mode 1) is chosen only when both the FIFO enable and the DMA mode control bits are set. In block mode, receive requests start at the trigger level or on a timeout and last until the receive side is drained. Transmit requests last for as long as any transmit slot is free. Both outputs are registered and follow their inputs by one clock.

Top module: `dma_ready_gen`

## Requirements
- R1: While reset is asserted and on the first edge after it, `rx_ready_n` is 1 and `tx_ready_n` is 0.
- R2: Block mode is in effect only when `fifo_en` and `dma_mode` are both 1; with `fifo_en` at 0 the block follows the mode 0 rules whatever `dma_mode` is.
- R3: In mode 0, one cycle after any `rx_count` value, `rx_ready_n` is 0 if that count was nonzero and 1 if it was zero.
- R4: In mode 0, one cycle after any `tx_count` value, `tx_ready_n` is 0 if that count was zero and 1 otherwise.
- R5: In block mode, when `rx_trig` or `rx_timeout` is 1 and `rx_count` is nonzero, `rx_ready_n` is 0 in the next cycle.
- R6: In block mode, once `rx_ready_n` is 0 it stays 0 while `rx_count` is nonzero, even after `rx_trig` drops.
- R7: In block mode, one cycle after `rx_count` is zero `rx_ready_n` is 1, even when `rx_trig` or `rx_timeout` is 1 in that cycle.
- R8: In block mode, a nonzero `rx_count` with neither `rx_trig` nor `rx_timeout` set leaves a high `rx_ready_n` high.
- R9: In block mode, one cycle after any `tx_count` value, `tx_ready_n` is 1 if that count equals `DEPTH` and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable control bit |
| dma_mode | input | 1 | DMA mode select control bit |
| rx_count | input | CW | Receive FIFO fill level (0..DEPTH) |
| rx_trig | input | 1 | Receive fill level is at or above the trigger level |
| rx_timeout | input | 1 | Receive timeout event |
| tx_count | input | CW | Transmit FIFO fill level (0..DEPTH) |
| rx_ready_n | output | 1 | Active-low receive DMA request |
| tx_ready_n | output | 1 | Active-low transmit DMA request |

## Verification
Every result is due exactly one clock after the inputs it depends on: both outputs are single registers, so a value driven before edge k shows at the outputs after edge k. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It then compares both pins at the next falling edge, which is a full cycle after the stimulus. The block-mode receive hold is checked over several cycles with the trigger removed and the count shrinking.

// File: rtl/dma_ready_gen.sv
module dma_ready_gen #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_trig,
  input  logic          rx_timeout,
  input  logic [CW-1:0] tx_count,
  output logic          rx_ready_n,
  output logic          tx_ready_n
);

  logic blk, rx_empty, tx_empty, tx_full;
  logic rx_nxt, tx_nxt;

  assign blk      = fifo_en & dma_mode;
  assign rx_empty = (rx_count == '0);
  assign tx_empty = (tx_count == '0);
  assign tx_full  = (tx_count == CW'(DEPTH));

  always_comb begin
    if (!blk) begin
      rx_nxt = rx_empty;
      tx_nxt = !tx_empty;
    end else begin
      tx_nxt = tx_full;
      if (rx_empty)                  rx_nxt = 1'b1;
      else if (rx_trig | rx_timeout) rx_nxt = 1'b0;
      else                           rx_nxt = rx_ready_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_ready_n <= 1'b1;
      tx_ready_n <= 1'b0;
    end else begin
      rx_ready_n <= rx_nxt;
      tx_ready_n <= tx_nxt;
    end

  // R3
  mode0_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fifo_en & dma_mode)) |-> (rx_ready_n == ($past(rx_count) == '0)));
  // R4
  mode0_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fifo_en & dma_mode)) |-> (tx_ready_n == ($past(tx_count) != '0)));
  // R5
  blk_rx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fifo_en & dma_mode & (rx_trig | rx_timeout)) && $past(rx_count) != '0)
      |-> !rx_ready_n);
  // R6
  blk_rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fifo_en & dma_mode) && $past(rx_count) != '0 && !$past(rx_ready_n))
      |-> !rx_ready_n);
  // R7
  blk_rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fifo_en & dma_mode) && $past(rx_count) == '0) |-> rx_ready_n);
  // R9
  blk_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fifo_en & dma_mode))
      |-> (tx_ready_n == ($past(tx_count) == CW'(DEPTH))));

endmodule

// File: tb/sim_dma_ready_gen.sv
`timescale 1ns/1ps
module sim_dma_ready_gen;
  localparam int DEPTH = 32;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, dma_mode = 0, rx_trig = 0, rx_timeout = 0;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic rx_ready_n, tx_ready_n;

  int tests = 0, fails = 0;
  int exp_rx = 1, exp_tx = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  dma_ready_gen #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .tx_count(tx_count), .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n));

  always @(posedge clk or negedge rst_n) begin
    int rc, tc;
    rc = int'(rx_count);
    tc = int'(tx_count);
    if (!rst_n) begin
      exp_rx = 1; exp_tx = 0;
    end else if (fifo_en && dma_mode) begin
      exp_tx = (tc == DEPTH) ? 1 : 0;
      if (rc == 0) exp_rx = 1;
      else if (rx_trig || rx_timeout) exp_rx = 0;
    end else begin
      exp_rx = (rc > 0) ? 0 : 1;
      exp_tx = (tc > 0) ? 1 : 0;
    end
  end

  task automatic cmp();
    tests++;
    if (int'(rx_ready_n) != exp_rx || int'(tx_ready_n) != exp_tx) begin
      fails++;
      $display("FAIL %s: rx_ready_n=%0d tx_ready_n=%0d expected %0d %0d",
               tag, rx_ready_n, tx_ready_n, exp_rx, exp_tx);
    end
  endtask

  task automatic cyc(input logic fe, input logic dm, input int rc,
                     input logic th, input logic to, input int tc);
    @(negedge clk);
    cmp();
    fifo_en = fe; dma_mode = dm; rx_count = CW'(rc);
    rx_trig = th; rx_timeout = to; tx_count = CW'(tc);
  endtask

  initial begin
    repeat (3) begin @(negedge clk); cmp(); end
    // R1: inputs that would otherwise move the outputs, held through reset
    fifo_en = 1; rx_count = 3; tx_count = 4;
    @(negedge clk); cmp();
    rst_n = 1;
    fifo_en = 0; rx_count = 0; tx_count = 0;
    cyc(1, 0, 0, 0, 0, 0);
    tag = "R3";
    cyc(1, 0, 1, 0, 0, 0); cyc(1, 0, 5, 0, 0, 0); cyc(1, 0, 32, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0); cyc(1, 0, 0, 1, 1, 0);
    tag = "R4";
    cyc(1, 0, 0, 0, 0, 1); cyc(1, 0, 0, 0, 0, 32); cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 7);
    tag = "R2";
    cyc(0, 1, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0, 1); cyc(0, 1, 1, 0, 0, 32);
    cyc(0, 0, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0);
    tag = "R8";
    cyc(1, 1, 4, 0, 0, 0); cyc(1, 1, 4, 0, 0, 0); cyc(1, 1, 9, 0, 0, 0);
    tag = "R5";
    cyc(1, 1, 9, 1, 0, 0); cyc(1, 1, 9, 1, 0, 0);
    tag = "R6";
    cyc(1, 1, 3, 0, 0, 0); cyc(1, 1, 2, 0, 0, 0); cyc(1, 1, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    tag = "R7";
    cyc(1, 1, 0, 0, 0, 0); cyc(1, 1, 0, 0, 0, 0);
    tag = "R5";
    cyc(1, 1, 2, 0, 1, 0); cyc(1, 1, 2, 0, 0, 0);
    tag = "R7";
    cyc(1, 1, 0, 1, 1, 0); cyc(1, 1, 0, 1, 0, 0); cyc(1, 1, 3, 0, 0, 0);
    tag = "R9";
    cyc(1, 1, 0, 0, 0, 32); cyc(1, 1, 0, 0, 0, 31); cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 32); cyc(1, 1, 0, 0, 0, 1);
    tag = "R2";
    cyc(1, 0, 0, 0, 0, 1); cyc(1, 1, 6, 0, 0, 0); cyc(1, 1, 6, 0, 0, 0);
    cyc(0, 1, 6, 0, 0, 0);
    @(negedge clk); cmp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20000;
    tests++; fails++;
    $display("FAIL watchdog: run did not complete, expected finish before 20000 ns");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule